// File: doc/BRIEF.md
# Interrupt Polarity Adapter with MDIO Management

This block sits on the wire between an external PHY's interrupt pin and the interrupt input of a MAC. The MAC only reacts to a rising edge. Some boards carry PHYs whose interrupt signals with a falling edge. To cover both, the adapter passes the PHY interrupt through a two-flop synchronizer. It then either forwards the result unchanged or inverts it, so the MAC always sees the event as a rising edge.

The inversion is chosen by one bit of a 16-bit configuration word. Software reaches that word over the management bus with Clause 22 frames. The block answers on one fixed PHY address and one register address, and ignores everything else on the bus. A read returns the full word exactly as it was last written, so firmware can use read-modify-write. MDC and MDIO are sampled with the block's own system clock through synchronizers. The bidirectional MDIO pin is split into an input, an output and an output enable.

Top module: `mdio_irq_pol_adapter`

## Requirements
- R1: After reset the configuration word is 0x0000, the MDIO output enable is low, and the MAC interrupt follows the PHY interrupt without inversion.
- R2: A frame with a preamble of at least 32 ones, start bits 0 then 1, opcode 01, PHY address 0x15, register address 0x00, turnaround 10 and 16 data bits (MSB first) stores those 16 bits in the configuration word.
- R3: A frame of the same shape with opcode 10 returns all 16 stored bits, MSB first, one bit per MDC period, unchanged from the last write.
- R4: During a read that hits, the block drives MDIO from the second turnaround bit through the last data bit. It drives 0 on that turnaround bit and releases the line after the last data bit. It never drives MDIO at any other time.
- R5: A frame addressed to any PHY address other than 0x15 leaves the configuration word unchanged. A read to such an address never drives MDIO.
- R6: A frame addressed to PHY 0x15 with a register address other than 0x00 leaves the word unchanged. A read of that register never drives MDIO.
- R7: A frame whose preamble has fewer than 32 consecutive ones is ignored.
- R8: With bit 6 of the configuration word clear, the MAC interrupt equals the PHY interrupt. With bit 6 set, it equals the inverted PHY interrupt. In both cases the output reflects an input change after exactly two system clock edges.
- R9: Configuration bits other than bit 6 are stored but have no effect on the MAC interrupt.
- R10: Frames with opcode 00 or 11 are ignored: no store and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample MDC and MDIO and to synchronize the interrupt |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data, input side of the pad |
| mdio_o | output | 1 | Management data, output side of the pad |
| mdio_oe_o | output | 1 | Output enable for the management data pad |
| phy_irq_i | input | 1 | Raw interrupt from the external PHY |
| mac_irq_o | output | 1 | Interrupt toward the MAC, polarity-corrected |

## Verification
The assertions assume that MDC is slow against the system clock. Each MDC phase must last several system clock cycles, and MDIO must stay stable around every MDC rising edge, so every bit is seen once and cleanly through the synchronizers. The bench keeps to this: each MDC half period spans five system clocks, and MDIO changes only when MDC falls. The latency property assumes the PHY interrupt is a level the synchronizer can capture. The bench changes it only at falling system clock edges and holds each value for at least two cycles.

// File: rtl/mdio_pol_pkg.sv
package mdio_pol_pkg;

    // Frame decoder states, in the order a frame is received
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_st_e;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam int         OP_W     = 2;
    localparam int         TA_BITS  = 2;

endpackage

// File: rtl/mdio_pol_sync.sv
module mdio_pol_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_comb begin
            stg_d[g] = stg_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mdio_pol_irq.sv
module mdio_pol_irq #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic pol_i,
    output logic irq_o
);

    logic irq_s;

    mdio_pol_sync #(.WIDTH(1), .STAGES(STAGES)) irq_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_i),
        .q_o   (irq_s)
    );

    // Inversion is applied after the synchronizer so the latency is fixed
    assign irq_o = irq_s ^ pol_i;

endmodule

// File: rtl/mdio_pol_frame.sv
module mdio_pol_frame
    import mdio_pol_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 5,
    parameter int          PRE_LEN  = 32,
    parameter logic [4:0]  PHY_ADDR = 5'h15,
    parameter logic [4:0]  REG_ADDR = 5'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_s,
    input  logic              mdio_s,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic [DATA_W-1:0] gcr_o,
    output logic              rd_hit_o
);

    localparam int HDR_W   = OP_W + 2 * ADDR_W;
    localparam int MAX_A   = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int CNT_MAX = (MAX_A > HDR_W) ? MAX_A : HDR_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        mdio_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic              rd_hit;
        logic              wr_hit;
        logic [DATA_W-1:0] shr;
        logic [DATA_W-1:0] gcr;
        logic              oe;
        logic              dout;
        logic              mdc_prev;
    } frame_s;

    frame_s fr_d, fr_q;

    logic              mdc_rise;
    logic [HDR_W-1:0]  hdr_full;
    logic [OP_W-1:0]   hdr_op;
    logic [ADDR_W-1:0] hdr_phy;
    logic [ADDR_W-1:0] hdr_reg;
    logic              hdr_match;

    always_comb begin
        fr_d      = fr_q;
        mdc_rise  = mdc_s & ~fr_q.mdc_prev;
        hdr_full  = {fr_q.hdr[HDR_W-2:0], mdio_s};
        hdr_op    = hdr_full[HDR_W-1 -: OP_W];
        hdr_phy   = hdr_full[2*ADDR_W-1 -: ADDR_W];
        hdr_reg   = hdr_full[ADDR_W-1:0];
        hdr_match = (hdr_phy == PHY_ADDR) && (hdr_reg == REG_ADDR);
        fr_d.mdc_prev = mdc_s;

        if (mdc_rise) begin
            unique case (fr_q.st)
                ST_IDLE: begin
                    // count consecutive ones; a zero after enough of them is the start bit
                    if (mdio_s) begin
                        if (fr_q.cnt != PRE_CNT) fr_d.cnt = fr_q.cnt + 1'b1;
                    end else if (fr_q.cnt == PRE_CNT) begin
                        fr_d.st  = ST_START;
                        fr_d.cnt = '0;
                    end else begin
                        fr_d.cnt = '0;
                    end
                end
                ST_START: begin
                    fr_d.cnt = '0;
                    fr_d.st  = mdio_s ? ST_HDR : ST_IDLE;
                end
                ST_HDR: begin
                    fr_d.hdr = hdr_full;
                    if (fr_q.cnt == HDR_LAST) begin
                        fr_d.rd_hit = hdr_match && (hdr_op == OP_READ);
                        fr_d.wr_hit = hdr_match && (hdr_op == OP_WRITE);
                        fr_d.st     = ST_TA;
                        fr_d.cnt    = '0;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_TA: begin
                    if (fr_q.cnt == '0) begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                        if (fr_q.rd_hit) begin
                            fr_d.oe   = 1'b1;
                            fr_d.dout = 1'b0;
                            fr_d.shr  = fr_q.gcr;
                        end
                    end else begin
                        fr_d.st  = ST_DATA;
                        fr_d.cnt = '0;
                        if (fr_q.rd_hit) begin
                            fr_d.dout = fr_q.shr[DATA_W-1];
                            fr_d.shr  = {fr_q.shr[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_DATA: begin
                    if (fr_q.rd_hit) begin
                        fr_d.dout = fr_q.shr[DATA_W-1];
                        fr_d.shr  = {fr_q.shr[DATA_W-2:0], 1'b0};
                    end else begin
                        fr_d.shr  = {fr_q.shr[DATA_W-2:0], mdio_s};
                    end
                    if (fr_q.cnt == DAT_LAST) begin
                        if (fr_q.wr_hit) fr_d.gcr = {fr_q.shr[DATA_W-2:0], mdio_s};
                        fr_d.st     = ST_IDLE;
                        fr_d.cnt    = '0;
                        fr_d.rd_hit = 1'b0;
                        fr_d.wr_hit = 1'b0;
                        fr_d.oe     = 1'b0;
                        fr_d.dout   = 1'b0;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: begin
                    fr_d.st  = ST_IDLE;
                    fr_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= ST_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign mdio_o    = fr_q.dout;
    assign mdio_oe_o = fr_q.oe;
    assign gcr_o     = fr_q.gcr;
    assign rd_hit_o  = fr_q.rd_hit;

endmodule

// File: rtl/mdio_irq_pol_adapter.sv
module mdio_irq_pol_adapter #(
    parameter int         DATA_W      = 16,
    parameter int         ADDR_W      = 5,
    parameter int         PRE_LEN     = 32,
    parameter int         SYNC_STAGES = 2,
    parameter int         POL_BIT     = 6,
    parameter logic [4:0] PHY_ADDR    = 5'h15,
    parameter logic [4:0] REG_ADDR    = 5'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdio_o,
    output logic mdio_oe_o,
    input  logic phy_irq_i,
    output logic mac_irq_o
);

    logic [1:0]        bus_s;
    logic [DATA_W-1:0] gcr_w;
    logic              rd_hit_w;

    // MDC and MDIO share one synchronizer so their relative timing is kept
    mdio_pol_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) bus_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mdc_i, mdio_i}),
        .q_o   (bus_s)
    );

    mdio_pol_frame #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .PRE_LEN  (PRE_LEN),
        .PHY_ADDR (PHY_ADDR),
        .REG_ADDR (REG_ADDR)
    ) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_s     (bus_s[1]),
        .mdio_s    (bus_s[0]),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .gcr_o     (gcr_w),
        .rd_hit_o  (rd_hit_w)
    );

    mdio_pol_irq #(.STAGES(SYNC_STAGES)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (phy_irq_i),
        .pol_i (gcr_w[POL_BIT]),
        .irq_o (mac_irq_o)
    );

endmodule

// File: rtl/mdio_pol_chk.sv
module mdio_pol_chk #(
    parameter int DATA_W  = 16,
    parameter int POL_BIT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phy_irq_i,
    input logic              mac_irq_o,
    input logic              mdio_o,
    input logic              mdio_oe_o,
    input logic [DATA_W-1:0] gcr,
    input logic              rd_hit
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 1'b1;
    end

    AST_GCR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gcr == '0)) else $error("gcr not cleared by reset"); // R1

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (mac_irq_o == ($past(phy_irq_i, 2) ^ gcr[POL_BIT])))
        else $error("irq output mismatch"); // R8

    AST_TA_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> !mdio_o) else $error("turnaround not low"); // R4

    AST_DRIVE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe_o |-> rd_hit) else $error("drive without read hit"); // R5

    AST_READ_KEEPS_GCR: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe_o |=> $stable(gcr)) else $error("gcr changed during read"); // R3

endmodule

bind mdio_irq_pol_adapter mdio_pol_chk #(.DATA_W(DATA_W), .POL_BIT(POL_BIT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phy_irq_i (phy_irq_i),
    .mac_irq_o (mac_irq_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .gcr       (gcr_w),
    .rd_hit    (rd_hit_w)
);

// File: tb/mdio_irq_pol_adapter_tb.sv
module mdio_irq_pol_adapter_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF_MDC   = 5;
    localparam int  WATCHDOG   = 150000;
    localparam logic [1:0] OPW = 2'b01;
    localparam logic [1:0] OPR = 2'b10;
    localparam logic [4:0] MY_PHY = 5'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic mdc_i = 1'b0;
    logic mdio_i = 1'b1;
    logic phy_irq_i = 1'b0;
    logic mdio_o, mdio_oe_o, mac_irq_o;

    int n_checks = 0;
    int n_errs   = 0;
    logic irq_prev = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_irq_pol_adapter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_i     (mdc_i),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .phy_irq_i (phy_irq_i),
        .mac_irq_o (mac_irq_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One MDC period: drive on the low phase, sample the pad just before the rise
    task automatic clock_bit(input logic b, output logic oe_s, output logic d_s);
        mdc_i  = 1'b0;
        mdio_i = b;
        repeat (HALF_MDC) @(negedge clk);
        oe_s = mdio_oe_o;
        d_s  = mdio_o;
        mdc_i = 1'b1;
        repeat (HALF_MDC) @(negedge clk);
    endtask

    task automatic run_frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input int pre, input bit exp_drive,
                             output logic [15:0] rd, output int oe_bad);
        logic oe_s, d_s;
        logic [11:0] hdr;
        bit is_wr;
        is_wr  = (op != OPR);
        oe_bad = 0;
        rd     = '0;
        hdr    = {op, pa, ra};
        for (int i = 0; i < pre; i++) begin
            clock_bit(1'b1, oe_s, d_s);
            if (oe_s !== 1'b0) oe_bad++;
        end
        clock_bit(1'b0, oe_s, d_s); if (oe_s !== 1'b0) oe_bad++;
        clock_bit(1'b1, oe_s, d_s); if (oe_s !== 1'b0) oe_bad++;
        for (int i = 11; i >= 0; i--) begin
            clock_bit(hdr[i], oe_s, d_s);
            if (oe_s !== 1'b0) oe_bad++;
        end
        clock_bit(1'b1, oe_s, d_s);
        if (oe_s !== 1'b0) oe_bad++;
        clock_bit(is_wr ? 1'b0 : 1'b1, oe_s, d_s);
        if (oe_s !== exp_drive) oe_bad++;
        if (exp_drive && d_s !== 1'b0) oe_bad++;
        for (int i = 15; i >= 0; i--) begin
            clock_bit(is_wr ? wd[i] : 1'b1, oe_s, d_s);
            if (oe_s !== exp_drive) oe_bad++;
            rd[i] = d_s;
        end
        clock_bit(1'b1, oe_s, d_s);
        if (oe_s !== 1'b0) oe_bad++;
    endtask

    task automatic do_write(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] val, input int pre);
        logic [15:0] rd;
        int bad;
        run_frame(op, pa, ra, val, pre, 1'b0, rd, bad);
        check(bad == 0, "R4", "drive during write frame", bad, 0);
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input bit exp_drive,
                           output logic [15:0] rd, output int bad);
        run_frame(OPR, pa, ra, 16'hFFFF, 32, exp_drive, rd, bad);
    endtask

    task automatic read_expect(input logic [15:0] exp, input string req);
        logic [15:0] rd;
        int bad;
        do_read(MY_PHY, 5'h00, 1'b1, rd, bad);
        check(rd == exp, req, "register read data", rd, exp);
        check(bad == 0, "R4", "read drive window", bad, 0);
    endtask

    // Change the PHY interrupt and confirm the two-edge latency and polarity
    task automatic irq_step(input logic v, input bit pol, input string req);
        phy_irq_i = v;
        @(negedge clk);
        check(mac_irq_o === (irq_prev ^ pol), req, "irq before second edge", mac_irq_o, irq_prev ^ pol);
        @(negedge clk);
        check(mac_irq_o === (v ^ pol), req, "irq after second edge", mac_irq_o, v ^ pol);
        irq_prev = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        check(mdio_oe_o === 1'b0, "R1", "oe after reset", mdio_oe_o, 0);
        check(mac_irq_o === 1'b0, "R1", "irq after reset", mac_irq_o, 0);
        irq_step(1'b1, 1'b0, "R1");
        irq_step(1'b0, 1'b0, "R1");
        read_expect(16'h0000, "R1");
    endtask

    task automatic test_write_read();
        logic [15:0] pats [4] = '{16'hA5C3, 16'hFFFF, 16'h0001, 16'h8000};
        foreach (pats[i]) begin
            do_write(OPW, MY_PHY, 5'h00, pats[i], 32);
            read_expect(pats[i], (i == 0) ? "R2" : "R3");
        end
    endtask

    task automatic test_other_phy();
        logic [15:0] rd;
        int bad;
        do_write(OPW, MY_PHY, 5'h00, 16'h1234, 32);
        do_write(OPW, 5'h14, 5'h00, 16'hBEEF, 32);
        do_read(5'h14, 5'h00, 1'b0, rd, bad);
        check(bad == 0, "R5", "no drive for foreign PHY", bad, 0);
        read_expect(16'h1234, "R5");
    endtask

    task automatic test_other_reg();
        logic [15:0] rd;
        int bad;
        do_write(OPW, MY_PHY, 5'h01, 16'h0F0F, 32);
        do_read(MY_PHY, 5'h01, 1'b0, rd, bad);
        check(bad == 0, "R6", "no drive for other register", bad, 0);
        read_expect(16'h1234, "R6");
    endtask

    task automatic test_bad_op();
        do_write(2'b00, MY_PHY, 5'h00, 16'h7777, 32);
        do_write(2'b11, MY_PHY, 5'h00, 16'h7777, 32);
        read_expect(16'h1234, "R10");
    endtask

    task automatic test_short_pre();
        do_write(OPW, MY_PHY, 5'h00, 16'h5555, 20);
        read_expect(16'h1234, "R7");
    endtask

    task automatic test_irq();
        do_write(OPW, MY_PHY, 5'h00, 16'hFFBF, 32);
        irq_step(1'b1, 1'b0, "R9");
        irq_step(1'b0, 1'b0, "R9");
        do_write(OPW, MY_PHY, 5'h00, 16'h0040, 32);
        repeat (2) @(negedge clk);
        check(mac_irq_o === 1'b1, "R8", "idle-low PHY line inverted", mac_irq_o, 1);
        irq_step(1'b1, 1'b1, "R8");
        irq_step(1'b0, 1'b1, "R8");
        irq_step(1'b1, 1'b1, "R8");
        read_expect(16'h0040, "R3");
        do_write(OPW, MY_PHY, 5'h00, 16'h0000, 32);
        repeat (2) @(negedge clk);
        check(mac_irq_o === 1'b1, "R8", "pass-through after clearing bit", mac_irq_o, 1);
        irq_step(1'b0, 1'b0, "R8");
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_write_read();
        test_other_phy();
        test_other_reg();
        test_bad_op();
        test_short_pre();
        test_irq();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule